// File: doc/BRIEF.md
# Sampled Digital Phase-Frequency Detector

This block compares a reference signal with a feedback signal from an oscillator and produces correction requests for a phase-locked loop. Both inputs are much slower than the system clock. Each input passes through a multi-flop synchronizer. A sampled 0 followed by a sampled 1 counts as a leading edge. Falling edges are never compared, so each input gives at most one comparison per input cycle. This gives a detection range of plus or minus 2π of phase difference, and the block detects frequency error as well as phase error.

Two internal state bits hold the pending request. A reference edge sets the "speed up" bit and a feedback edge sets the "slow down" bit. When both bits would be set in the same clock cycle, both clear instead. The request outputs are active-low: they stay high while idle and pulse low while a request is pending. The low pulse is as long, in clock cycles, as the offset between the two edges. Each request output also has a complementary, active-high copy. A charge pump or digital loop filter downstream integrates the difference between the two requests.

Top module: `pfd_sampled`

## Requirements
- R1: While `rst_n` is low, and after reset until the first input edge, `up_n` and `dn_n` are high and `up_p` and `dn_p` are low. Reset acts at once, even while a request is pending.
- R2: With equal input periods and the reference edge leading by d clock cycles (0 < d), `up_n` goes low once per period for exactly d cycles and `dn_n` stays high. Once set, the request holds until a feedback edge arrives.
- R3: With equal input periods and the feedback edge leading by d clock cycles, `dn_n` goes low once per period for exactly d cycles and `up_n` stays high.
- R4: When both inputs rise in the same sampling cycle, neither `up_n` nor `dn_n` goes low.
- R5: When the feedback frequency is above the reference frequency and both start with coincident edges, only `dn_n` produces low pulses and `up_n` never goes low.
- R6: When the feedback frequency is below the reference frequency and both start with coincident edges, only `up_n` produces low pulses and `dn_n` never goes low.
- R7: At a half-period offset (180°), the active request is low for exactly half of each input period, in either direction.
- R8: `up_p` is always the inverse of `up_n`, and `dn_p` is always the inverse of `dn_n`.
- R9: `up_n` and `dn_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| ref_in | input | 1 | Reference input, asynchronous to clk |
| fb_in | input | 1 | Feedback (oscillator) input, asynchronous to clk |
| up_n | output | 1 | Speed-up request, active-low |
| up_p | output | 1 | Complement of up_n |
| dn_n | output | 1 | Slow-down request, active-low |
| dn_p | output | 1 | Complement of dn_n |

## Verification
An input level first captured at clock edge E0 sets or clears a request at edge E0+SYNC_STAGES. Both inputs travel through identical paths, so the width of a low pulse equals the edge offset in cycles with no correction. The bench changes the inputs on falling clock edges and measures each pulse on falling edges by counting consecutive low samples. The pulse is compared against the queued expectation when the output returns high, so the fixed latency never enters the check. After each stimulus burst the bench idles for more than the pipeline depth and then checks that no expected pulse is still outstanding.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Pending correction request held between the two leading edges.
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_req_t;

  // Shortest synchronizer chain the block accepts.
  localparam int unsigned PFD_MIN_SYNC = 2;
  // Bit positions of the two inputs inside the shared synchronizer bus.
  localparam int unsigned PFD_REF_BIT = 0;
  localparam int unsigned PFD_FB_BIT  = 1;
  localparam int unsigned PFD_NUM_IN  = 2;
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb chain_d[s] = d_async;
    end else begin : g_next
      always_comb chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[s] <= '0;
      end else begin
        chain_q[s] <= chain_d[s];
      end
    end
  end

  assign q_sync = chain_q[LAST];
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb prev_d = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  // Leading edge: previous sample 0, current sample 1.
  assign rise = level & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_rise,
  input  logic     fb_rise,
  output pfd_req_t req_q
);
  pfd_req_t req_d;
  pfd_req_t req_set;

  always_comb begin
    req_set.up = req_q.up | ref_rise;
    req_set.dn = req_q.dn | fb_rise;
    if (req_set.up && req_set.dn) begin
      // Both edges have now been seen: the comparison is complete.
      req_d = '0;
    end else begin
      req_d = req_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/pfd_sampled.sv
module pfd_sampled
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_n,
  output logic up_p,
  output logic dn_n,
  output logic dn_p
);
  localparam int unsigned STAGES_USED =
    (SYNC_STAGES < PFD_MIN_SYNC) ? PFD_MIN_SYNC : SYNC_STAGES;

  logic [PFD_NUM_IN-1:0] raw_in;
  logic [PFD_NUM_IN-1:0] sync_lvl;
  logic [PFD_NUM_IN-1:0] lvl_rise;
  logic                  r_rise;
  logic                  v_rise;
  pfd_req_t              req_q;

  always_comb begin
    raw_in              = '0;
    raw_in[PFD_REF_BIT] = ref_in;
    raw_in[PFD_FB_BIT]  = fb_in;
  end

  pfd_sync #(
    .WIDTH  (PFD_NUM_IN),
    .STAGES (STAGES_USED)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .q_sync  (sync_lvl)
  );

  pfd_edge #(
    .WIDTH (PFD_NUM_IN)
  ) edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .level (sync_lvl),
    .rise  (lvl_rise)
  );

  assign r_rise = lvl_rise[PFD_REF_BIT];
  assign v_rise = lvl_rise[PFD_FB_BIT];

  pfd_core core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (r_rise),
    .fb_rise  (v_rise),
    .req_q    (req_q)
  );

  assign up_n = ~req_q.up;
  assign up_p =  req_q.up;
  assign dn_n = ~req_q.dn;
  assign dn_p =  req_q.dn;
endmodule

// File: rtl/pfd_sampled_chk.sv
module pfd_sampled_chk (
  input logic clk,
  input logic rst_n,
  input logic r_rise,
  input logic v_rise,
  input logic up_n,
  input logic dn_n
);
  // R1: outputs idle while reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_idle_in_reset_R1: assert (up_n && dn_n)
        else $error("request active during reset");
    end
  end

  // R2: a speed-up request starts only after a sampled reference edge.
  assert_up_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_n) |-> $past(r_rise));

  // R2: a speed-up request ends only on a sampled feedback edge.
  assert_up_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_n) |-> $past(v_rise));

  // R3: a slow-down request starts only after a sampled feedback edge.
  assert_dn_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_n) |-> $past(v_rise));

  // R3: a slow-down request ends only on a sampled reference edge.
  assert_dn_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_n) |-> $past(r_rise));

  // R4: coincident edges leave both requests inactive.
  assert_coincident_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rise && v_rise) |=> (up_n && dn_n));

  // R9: never both requests at once.
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!up_n && !dn_n));
endmodule

bind pfd_sampled pfd_sampled_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .r_rise (r_rise),
  .v_rise (v_rise),
  .up_n   (up_n),
  .dn_n   (dn_n)
);

// File: tb/pfd_sampled_tb_top.sv
module pfd_sampled_tb_top;
  typedef struct {
    bit    is_up;
    int    width;
    string req;
  } pulse_t;

  logic clk;
  logic rst_n;
  logic ref_in;
  logic fb_in;
  logic up_n, up_p, dn_n, dn_p;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pulse_t exp_q[$];
  bit     sb_on = 1;
  int     run_up = 0;
  int     run_dn = 0;
  int     falls_up = 0;
  int     falls_dn = 0;
  int     comp_err = 0;
  int     both_err = 0;

  pfd_sampled #(.SYNC_STAGES(2)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_in),
    .fb_in  (fb_in),
    .up_n   (up_n),
    .up_p   (up_p),
    .dn_n   (dn_n),
    .dn_p   (dn_p)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tally(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Monitor: measures low pulses and checks them against the scoreboard.
  task automatic pulse_end(input bit is_up, input int width);
    pulse_t e;
    if (!sb_on) begin
      if (is_up) falls_up++; else falls_dn++;
    end else if (exp_q.size() == 0) begin
      tally(1'b0, is_up ? "R2" : "R3", width, 0);
    end else begin
      e = exp_q.pop_front();
      tally(e.is_up == is_up, e.req, int'(is_up), int'(e.is_up));
      tally(e.width == width, e.req, width, e.width);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      run_up = 0;
      run_dn = 0;
    end else begin
      if (up_n === 1'b0) run_up++;
      else if (run_up > 0) begin pulse_end(1'b1, run_up); run_up = 0; end
      if (dn_n === 1'b0) run_dn++;
      else if (run_dn > 0) begin pulse_end(1'b0, run_dn); run_dn = 0; end
      if (up_n === 1'b0 && dn_n === 1'b0) both_err++;
      if (up_p !== ~up_n || dn_p !== ~dn_n) comp_err++;
    end
  end

  task automatic check_idle(input string req);
    tally(up_n === 1'b1, req, int'(up_n), 1);
    tally(dn_n === 1'b1, req, int'(dn_n), 1);
    tally(up_p === 1'b0, req, int'(up_p), 0);
    tally(dn_p === 1'b0, req, int'(dn_p), 0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Driver: equal periods, feedback delayed by off cycles (negative: leads).
  task automatic run_phase(input int period, input int off, input int reps, input string req);
    int ro = (off < 0) ? -off : 0;
    int vo = (off > 0) ? off : 0;
    pulse_t e;
    for (int k = 0; k < reps; k++) begin
      if (off != 0) begin
        e.is_up = (off > 0);
        e.width = (off > 0) ? off : -off;
        e.req   = req;
        exp_q.push_back(e);
      end
    end
    for (int k = 0; k < reps; k++) begin
      for (int c = 0; c < period; c++) begin
        @(negedge clk);
        ref_in = (((c - ro + period) % period) < period / 2);
        fb_in  = (((c - vo + period) % period) < period / 2);
      end
    end
    @(negedge clk);
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (12) @(negedge clk);
    tally(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Frequency offset: both start with a coincident edge.
  task automatic run_freq(input int pr, input int pv, input int cycles, input bit up_side, input string req);
    apply_reset();
    sb_on    = 1'b0;
    falls_up = 0;
    falls_dn = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      ref_in = ((c % pr) < pr / 2);
      fb_in  = ((c % pv) < pv / 2);
    end
    @(negedge clk);
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (6) @(negedge clk);
    if (up_side) begin
      tally(falls_up > 0, req, falls_up, 1);
      tally(falls_dn == 0 && dn_n === 1'b1, req, falls_dn, 0);
    end else begin
      tally(falls_dn > 0, req, falls_dn, 1);
      tally(falls_up == 0 && up_n === 1'b1, req, falls_up, 0);
    end
    apply_reset();
    sb_on = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tally(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    rst_n  = 1'b0;
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_idle("R1");

    run_phase(16,  3, 4, "R2");
    run_phase(16,  6, 3, "R2");
    run_phase(16, -2, 4, "R3");
    run_phase(20, -7, 3, "R3");
    run_phase(16,  0, 4, "R4");
    run_phase(16,  8, 3, "R7");
    run_phase(16, -8, 3, "R7");

    tally(comp_err == 0, "R8", comp_err, 0);
    tally(both_err == 0, "R9", both_err, 0);

    run_freq(8, 13, 300, 1'b1, "R6");
    run_freq(13, 8, 300, 1'b0, "R5");

    // R2 / R1: a lone reference edge latches the request until reset.
    sb_on = 1'b0;
    @(negedge clk);
    ref_in = 1'b1;
    repeat (8) @(negedge clk);
    tally(up_n === 1'b0, "R2", int'(up_n), 0);
    rst_n = 1'b0;
    #1;
    tally(up_n === 1'b1 && up_p === 1'b0, "R1", int'(up_n), 1);
    ref_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    tally(comp_err == 0, "R8", comp_err, 0);
    tally(both_err == 0, "R9", both_err, 0);
    summary();
  end
endmodule